// File: doc/BRIEF.md
# External Reset Pulse Generator

This block turns a single-cycle trigger strobe from a watchdog core into a reset pulse on an external pin. The pulse length is set in whole microseconds. The block does not divide the clock itself. It counts a one-cycle tick enable that arrives once per microsecond. A width value of N gives a pulse of N+1 ticks. A trigger that arrives during a pulse starts the count again.

One 32-bit configuration register holds three settings:

- The pulse width, in the low `WIDTH_W` bits.
- The output polarity, read back in bit 31.
- The drive mode, read back in bit 30.

The two mode bits are not ordinary read/write bits. A mode bit changes only when a write carries one of four key bytes in bits 31:24. Every write updates the width field. The pin is presented as a value and an output enable, so open-drain drive can be modelled. In open-drain mode the enable is raised only while the pin is at its asserted level.

Top module: `xrst_pulse_gen`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 0x000000FF: width 255, bit 31 = 0 (active low), bit 30 = 0 (open-drain). The pin is not driven (`pin_oe_o` = 0).
- R2: Every write loads `cfg_wdata_i[WIDTH_W-1:0]` into the width field. Bits 29 down to `WIDTH_W` always read zero.
- R3: A write whose bits 31:24 are 0xA5 sets bit 31 (active high). A write whose bits 31:24 are 0x5A clears bit 31 (active low).
- R4: A write whose bits 31:24 are 0xA8 sets bit 30 (push-pull). A write whose bits 31:24 are 0x8A clears bit 30 (open-drain).
- R5: A write with any other value in bits 31:24 leaves bits 31 and 30 unchanged.
- R6: The pin is asserted from the cycle after `trig_i` is sampled. It stays asserted through N `tick_i` pulses. It deasserts in the cycle after the (N+1)th tick, where N is the width.
- R7: Clock cycles without `tick_i` do not shorten a pulse. Ticks while no pulse is running have no effect.
- R8: A trigger during a pulse restarts the count, so N+1 further ticks are needed. A trigger in the same cycle as a tick takes precedence over that tick.
- R9: While asserted, `pin_o` equals bit 31. While deasserted in push-pull mode, `pin_o` drives the inverse of bit 31.
- R10: In push-pull mode `pin_oe_o` is always 1. In open-drain mode `pin_oe_o` is 1 only while the pulse is asserted.
- R11: The width is captured when the trigger is taken. A width write during a pulse affects only later pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read-back |
| tick_i | input | 1 | One-cycle 1 µs tick enable |
| trig_i | input | 1 | Pulse trigger from the watchdog core |
| pin_o | output | 1 | Pin output value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The bench counts ticks one by one around the final tick of a pulse. An off-by-one in the width would show up as a pulse one tick short or long. The default width is checked with a tick held high for 256 cycles, which catches a counter that is too narrow or starts at the wrong value.

Three timing cases are aimed at:

- A retrigger placed mid-pulse, and a retrigger that coincides with a tick. A design that lets the tick win, or ignores the retrigger, ends the pulse early.
- A width write made mid-pulse. A design that does not capture the width at the trigger would stretch the running pulse.

The key decoder gets each key, a non-key top byte and an all-ones word. A decoder that matches loosely or clears the mode bits would flip polarity or drive mode. Open-drain and push-pull runs in both polarities expose an enable that is left driving while deasserted, or a level that is inverted.

// File: rtl/xrst_pkg.sv
package xrst_pkg;
  localparam logic [7:0] KEY_ACT_HIGH  = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW   = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRN  = 8'h8A;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned POL_BIT      = 31;
  localparam int unsigned DRV_BIT      = 30;

  typedef enum logic {DRV_OPEN_DRAIN = 1'b0, DRV_PUSH_PULL = 1'b1} drv_mode_e;

  typedef struct packed {
    logic      act_high;
    drv_mode_e drv;
  } pin_mode_t;
endpackage

// File: rtl/xrst_cfg_reg.sv
module xrst_cfg_reg
  import xrst_pkg::*;
#(
  parameter int unsigned WIDTH_W   = 8,
  parameter int unsigned RST_WIDTH = 255
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic [WIDTH_W-1:0]  width_o,
  output pin_mode_t           mode_o
);
  localparam int unsigned PAD_W = REG_W - 2 - WIDTH_W;
  localparam logic [WIDTH_W-1:0] WIDTH_RST = WIDTH_W'(RST_WIDTH);

  logic [7:0]         key;
  logic [WIDTH_W-1:0] width_q;
  pin_mode_t          mode_q, mode_d;

  assign key = wdata_i[REG_W-1 -: 8];

  // Keys act on one mode bit each; anything else keeps both.
  always_comb begin
    mode_d = mode_q;
    unique case (key)
      KEY_ACT_HIGH:  mode_d.act_high = 1'b1;
      KEY_ACT_LOW:   mode_d.act_high = 1'b0;
      KEY_PUSH_PULL: mode_d.drv      = DRV_PUSH_PULL;
      KEY_OPEN_DRN:  mode_d.drv      = DRV_OPEN_DRAIN;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= WIDTH_RST;
      mode_q  <= '{act_high: 1'b0, drv: DRV_OPEN_DRAIN};
    end else if (we_i) begin
      width_q <= wdata_i[WIDTH_W-1:0];
      mode_q  <= mode_d;
    end
  end

  assign rdata_o = {mode_q.act_high, mode_q.drv == DRV_PUSH_PULL, {PAD_W{1'b0}}, width_q};
  assign width_o = width_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/xrst_timer.sv
module xrst_timer #(
  parameter int unsigned WIDTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic               tick_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_on_o
);
  logic [WIDTH_W-1:0] left_q;
  logic               on_q;

  // Width is captured at the trigger; the pulse ends on the tick that finds zero left.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= 1'b0;
      left_q <= '0;
    end else if (trig_i) begin
      on_q   <= 1'b1;
      left_q <= width_i;
    end else if (on_q && tick_i) begin
      if (left_q == '0) on_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  assign pulse_on_o = on_q;
endmodule

// File: rtl/xrst_pin_drv.sv
module xrst_pin_drv
  import xrst_pkg::*;
(
  input  logic      pulse_on_i,
  input  pin_mode_t mode_i,
  output logic      pin_o,
  output logic      pin_oe_o
);
  assign pin_o    = pulse_on_i ? mode_i.act_high : ~mode_i.act_high;
  assign pin_oe_o = (mode_i.drv == DRV_PUSH_PULL) | pulse_on_i;
endmodule

// File: rtl/xrst_pulse_gen.sv
module xrst_pulse_gen
  import xrst_pkg::*;
#(
  parameter int unsigned WIDTH_W   = 8,
  parameter int unsigned RST_WIDTH = 255
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        tick_i,
  input  logic        trig_i,
  output logic        pin_o,
  output logic        pin_oe_o
);
  logic [WIDTH_W-1:0] width;
  pin_mode_t          mode;
  logic               pulse_on;

  xrst_cfg_reg #(.WIDTH_W(WIDTH_W), .RST_WIDTH(RST_WIDTH)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .width_o (width),
    .mode_o  (mode)
  );

  xrst_timer #(.WIDTH_W(WIDTH_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .tick_i     (tick_i),
    .width_i    (width),
    .pulse_on_o (pulse_on)
  );

  xrst_pin_drv u_drv (
    .pulse_on_i (pulse_on),
    .mode_i     (mode),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
  );
endmodule

// File: rtl/xrst_chk.sv
module xrst_chk #(
  parameter int unsigned WIDTH_W = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [31:0] cfg_wdata_i,
  input logic [31:0] cfg_rdata_o,
  input logic        tick_i,
  input logic        trig_i,
  input logic        pin_o,
  input logic        pin_oe_o,
  input logic        pulse_on
);
  logic pol_key, drv_key;
  assign pol_key = cfg_wdata_i[31:24] == 8'hA5 || cfg_wdata_i[31:24] == 8'h5A;
  assign drv_key = cfg_wdata_i[31:24] == 8'hA8 || cfg_wdata_i[31:24] == 8'h8A;

  // R2
  width_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o[WIDTH_W-1:0] == $past(cfg_wdata_i[WIDTH_W-1:0]));

  // R5
  pol_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !pol_key) |=> $stable(cfg_rdata_o[31]));

  // R5
  drv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !drv_key) |=> $stable(cfg_rdata_o[30]));

  // R6
  trig_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> pulse_on && pin_oe_o && pin_o == cfg_rdata_o[31]);

  // R7
  end_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_on) |-> $past(tick_i) && !$past(trig_i));

  // R10
  pp_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[30] |-> pin_oe_o);

  // R10
  od_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rdata_o[30] && pin_oe_o) |-> pin_o == cfg_rdata_o[31]);
endmodule

bind xrst_pulse_gen xrst_chk #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .tick_i      (tick_i),
  .trig_i      (trig_i),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .pulse_on    (pulse_on)
);

// File: tb/sim_xrst_pulse_gen.sv
`timescale 1ns/1ps
module sim_xrst_pulse_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        trig = 1'b0;
  logic        pin, pin_oe;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  xrst_pulse_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .tick_i(tick), .trig_i(trig), .pin_o(pin), .pin_oe_o(pin_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    we = 1'b1; wdata = d; step(); we = 1'b0;
  endtask

  task automatic fire();
    trig = 1'b1; step(); trig = 1'b0;
  endtask

  task automatic one_tick();
    tick = 1'b1; step(); tick = 1'b0; step();
  endtask

  function automatic bit asserted(input logic pol);
    return pin_oe && pin == pol;
  endfunction

  task automatic t_reset();
    chk(rdata == 32'h0000_00FF, "R1 reset read", rdata, 32'h0000_00FF);
    chk(pin_oe == 1'b0, "R1 pin released", {31'b0, pin_oe}, 32'h0);
  endtask

  task automatic t_default_len();
    int n = 0;
    trig = 1'b1; step(); trig = 1'b0; tick = 1'b1;
    while (asserted(1'b0) && n < 1000) begin n++; step(); end
    tick = 1'b0;
    chk(n == 256, "R6 default width pulse ticks", n, 256);
    chk(pin_oe == 1'b0, "R10 open-drain released after pulse", {31'b0, pin_oe}, 32'h0);
  endtask

  task automatic t_keys();
    wr(32'hA500_0003); chk(rdata == 32'h8000_0003, "R3 active-high key", rdata, 32'h8000_0003);
    wr(32'hA800_0005); chk(rdata == 32'hC000_0005, "R4 push-pull key", rdata, 32'hC000_0005);
    wr(32'h1200_00AB); chk(rdata == 32'hC000_00AB, "R5 non-key byte", rdata, 32'hC000_00AB);
    wr(32'hFFFF_FFFF); chk(rdata == 32'hC000_00FF, "R2 R5 all-ones write", rdata, 32'hC000_00FF);
    wr(32'h5A00_0007); chk(rdata == 32'h4000_0007, "R3 active-low key", rdata, 32'h4000_0007);
    wr(32'h8A00_0002); chk(rdata == 32'h0000_0002, "R4 open-drain key", rdata, 32'h0000_0002);
    wr(32'hA600_0011); chk(rdata == 32'h0000_0011, "R5 near-key byte", rdata, 32'h0000_0011);
  endtask

  // Width n, mode already set; checks pulse spans exactly n+1 ticks.
  task automatic t_pulse(input int n, input logic pol, input logic pp, input string tag);
    chk(pin_oe == pp, {tag, " R10 idle enable"}, {31'b0, pin_oe}, {31'b0, pp});
    if (pp) chk(pin == ~pol, {tag, " R9 idle level"}, {31'b0, pin}, {31'b0, ~pol});
    fire();
    chk(asserted(pol), {tag, " R6 asserted after trigger"}, {30'b0, pin_oe, pin}, {30'b0, 1'b1, pol});
    for (int i = 0; i < n; i++) one_tick();
    repeat (5) step();
    chk(asserted(pol), {tag, " R7 holds through N ticks and idle cycles"}, {30'b0, pin_oe, pin}, {30'b0, 1'b1, pol});
    one_tick();
    chk(!asserted(pol), {tag, " R6 ends after N+1 ticks"}, {30'b0, pin_oe, pin}, {30'b0, pp, ~pol});
    chk(pin_oe == pp, {tag, " R10 enable after pulse"}, {31'b0, pin_oe}, {31'b0, pp});
  endtask

  task automatic t_idle_ticks();
    repeat (4) one_tick();
    chk(pin_oe == 1'b0, "R7 ticks with no pulse", {31'b0, pin_oe}, 32'h0);
  endtask

  task automatic t_retrig();
    wr(32'h0000_0003);
    fire(); one_tick(); one_tick();
    trig = 1'b1; tick = 1'b1; step(); trig = 1'b0; tick = 1'b0;
    for (int i = 0; i < 3; i++) one_tick();
    chk(asserted(1'b0), "R8 restart keeps pulse after 3 ticks", {30'b0, pin_oe, pin}, 32'h2);
    one_tick();
    chk(!asserted(1'b0), "R8 restart ends after 4 ticks", {30'b0, pin_oe, pin}, 32'h1);
  endtask

  task automatic t_capture();
    wr(32'h0000_0001);
    fire();
    wr(32'h0000_0009);
    one_tick();
    chk(asserted(1'b0), "R11 one tick into width-1 pulse", {30'b0, pin_oe, pin}, 32'h2);
    one_tick();
    chk(!asserted(1'b0), "R11 width write mid-pulse ignored", {30'b0, pin_oe, pin}, 32'h1);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_default_len();
    t_keys();
    t_idle_ticks();
    wr(32'h0000_0004); t_pulse(4, 1'b0, 1'b0, "od-low");
    wr(32'hA500_0002); t_pulse(2, 1'b1, 1'b0, "od-high");
    wr(32'hA800_0000); t_pulse(0, 1'b1, 1'b1, "pp-high");
    wr(32'h5A00_0003); t_pulse(3, 1'b0, 1'b1, "pp-low");
    wr(32'h8A00_0000);
    t_retrig();
    t_capture();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule